// File: doc/BRIEF.md
# Channel-Power Normalized Chip Estimator

This block sits in a direct-sequence spread-spectrum receiver, after the correlation loops. When the channel-power accumulation finishes, the result is loaded into the block. A sequential divider then forms the power reciprocal in fixed point. The numerator is the all-ones positive fraction, and the 18 power bits are read unchanged as an unsigned integer divisor.

Once the reciprocal is valid, each complex correlator sum that arrives with a chip strobe is scaled by it, one multiply for the real part and one for the imaginary part. The scaled estimate goes out on a registered port and is also stored in a chip-indexed estimate memory, at the oversampled chip index that came with the sum. A second strobe turns the same accumulator inputs into a despread symbol estimate. The despread path uses a plain arithmetic right shift and no multiplier. No step rounds; every narrowing truncates.

Top module: `chip_norm_est`

## Requirements
- R1: After synchronous reset: recip_valid, recip_done, div_zero, est_we and sym_out_vld are all 0.
- R2: For a nonzero power P on pwr_acc (18 bits, read as unsigned), recip equals floor(131071 / P). Any P above 131071 gives 0.
- R3: A nonzero load, sampled on clock edge e0, drops recip_valid at e0. recip_valid and a one-cycle recip_done rise at edge e0+18, one edge per quotient bit.
- R4: A load of zero sets recip to all ones (0x3FFFF) at the load edge, with recip_valid and recip_done. It also sets div_zero, which stays set until reset even after later nonzero loads.
- R5: A chip strobe sampled while recip_valid is 1 gives est_we two edges later. est_re equals bits [34:17] of the signed product acc_re × recip, and est_im is formed the same way from acc_im. This is floor((acc × recip) / 2^17) truncated to 18 bits.
- R6: A chip strobe sampled while recip_valid is 0 is ignored. No est_we pulse follows, and the memory word at that index keeps its old value.
- R7: Each estimate goes out with est_addr equal to the chip_idx sampled with its strobe. It is written into the estimate memory at that address. Setting rd_addr returns {re, im} on rd_re/rd_im one edge later.
- R8: A symbol strobe gives sym_out_vld one edge later. sym_re and sym_im equal acc_re and acc_im arithmetically shifted right by 9, kept as 9-bit signed values.
- R9: While recip_valid is 1 and no load arrives, recip holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_load | input | 1 | Starts a reciprocal computation from pwr_acc |
| pwr_acc | input | 18 | Accumulated channel power, fractional |
| acc_re | input | 18 | Correlator sum, real part, signed |
| acc_im | input | 18 | Correlator sum, imaginary part, signed |
| chip_vld | input | 1 | Chip-estimate strobe for acc_re/acc_im |
| chip_idx | input | 5 | Oversampled chip index for the estimate |
| sym_vld | input | 1 | Despread strobe for acc_re/acc_im |
| rd_addr | input | 5 | Estimate memory read address |
| recip | output | 18 | Power reciprocal |
| recip_valid | output | 1 | Reciprocal is usable |
| recip_done | output | 1 | One-cycle pulse when a reciprocal completes |
| div_zero | output | 1 | Sticky flag: a zero power was loaded |
| est_we | output | 1 | Estimate output valid / memory write |
| est_addr | output | 5 | Chip index of the estimate |
| est_re | output | 18 | Scaled estimate, real |
| est_im | output | 18 | Scaled estimate, imaginary |
| rd_re | output | 18 | Stored estimate, real |
| rd_im | output | 18 | Stored estimate, imaginary |
| sym_out_vld | output | 1 | Despread output valid |
| sym_re | output | 9 | Despread estimate, real |
| sym_im | output | 9 | Despread estimate, imaginary |

## Verification
The results are due at fixed edges:

- A nonzero reciprocal appears exactly 18 edges after its load edge. The bench checks that recip_valid is still low after edge 17, then checks value and done after edge 18.
- A zero reciprocal lands on the load edge itself.
- A chip estimate is sampled on the falling edge after the second rising edge following its strobe.
- A despread symbol is sampled after the first rising edge.
- A memory read is sampled two edges after rd_addr is set, so the write from the estimate path has already landed.

Every input is driven on a falling edge, so no check races the clock.

// File: rtl/chip_est_pkg.sv
package chip_est_pkg;
  typedef enum logic {DIV_IDLE, DIV_RUN} div_state_e;
endpackage

// File: rtl/chip_est_recip.sv
module chip_est_recip
  import chip_est_pkg::*;
#(
  parameter int PWR_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PWR_W-1:0] pwr,
  output logic [PWR_W-1:0] recip,
  output logic             valid,
  output logic             done,
  output logic             dz
);
  localparam int CNT_W = $clog2(PWR_W + 1);
  localparam logic [PWR_W-1:0] NUM = {1'b0, {(PWR_W-1){1'b1}}};

  div_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [PWR_W-1:0] dvd, dvs, rem;
  logic [PWR_W-2:0] quo;
  logic [PWR_W:0]   rem_sh, diff;
  logic             fits;

  // one restoring step: shift in next numerator bit, subtract if it fits
  always_comb begin
    rem_sh = {rem, dvd[PWR_W-1]};
    diff   = rem_sh - {1'b0, dvs};
    fits   = ~diff[PWR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= DIV_IDLE;
      cnt   <= '0;
      dvd   <= '0;
      dvs   <= '0;
      rem   <= '0;
      quo   <= '0;
      recip <= '0;
      valid <= 1'b0;
      done  <= 1'b0;
      dz    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        if (pwr == '0) begin
          recip <= '1;
          valid <= 1'b1;
          done  <= 1'b1;
          dz    <= 1'b1;
          st    <= DIV_IDLE;
        end else begin
          st    <= DIV_RUN;
          valid <= 1'b0;
          cnt   <= CNT_W'(PWR_W);
          dvd   <= NUM;
          dvs   <= pwr;
          rem   <= '0;
          quo   <= '0;
        end
      end else if (st == DIV_RUN) begin
        rem <= fits ? diff[PWR_W-1:0] : rem_sh[PWR_W-1:0];
        dvd <= {dvd[PWR_W-2:0], 1'b0};
        quo <= {quo[PWR_W-3:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          recip <= {quo, fits};
          valid <= 1'b1;
          done  <= 1'b1;
          st    <= DIV_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/chip_est_scale.sv
module chip_est_scale #(
  parameter int ACC_W = 18,
  parameter int PWR_W = 18,
  parameter int IDX_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_re,
  input  logic signed [ACC_W-1:0] in_im,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [PWR_W-1:0]        recip,
  input  logic                    recip_ok,
  output logic                    out_vld,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [ACC_W-1:0] out_re,
  output logic signed [ACC_W-1:0] out_im
);
  localparam int FRAC   = PWR_W - 1;
  localparam int PROD_W = ACC_W + PWR_W + 1;

  logic signed [ACC_W-1:0]  lane_in  [2];
  logic signed [PROD_W-1:0] lane_p   [2];
  logic signed [ACC_W-1:0]  lane_s1  [2];
  logic                     s1_vld;
  logic [IDX_W-1:0]         s1_idx;

  assign lane_in[0] = in_re;
  assign lane_in[1] = in_im;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb lane_p[g] = lane_in[g] * $signed({1'b0, recip});
    always_ff @(posedge clk) begin
      if (rst) lane_s1[g] <= '0;
      else     lane_s1[g] <= lane_p[g][FRAC+ACC_W-1:FRAC];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_idx  <= '0;
      out_vld <= 1'b0;
      out_idx <= '0;
      out_re  <= '0;
      out_im  <= '0;
    end else begin
      s1_vld  <= in_vld && recip_ok;
      s1_idx  <= in_idx;
      out_vld <= s1_vld;
      out_idx <= s1_idx;
      out_re  <= lane_s1[0];
      out_im  <= lane_s1[1];
    end
  end
endmodule

// File: rtl/chip_est_mem.sv
module chip_est_mem #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/chip_est_despread.sv
module chip_est_despread #(
  parameter int ACC_W = 18,
  parameter int SHIFT = 9,
  localparam int OUT_W = ACC_W - SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [OUT_W-1:0] in_re_hi,
  input  logic signed [OUT_W-1:0] in_im_hi,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  // the upper bits of a signed word are its arithmetic right shift
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_re <= in_re_hi;
        out_im <= in_im_hi;
      end
    end
  end
endmodule

// File: rtl/chip_norm_est.sv
module chip_norm_est #(
  parameter int PWR_W = 18,
  parameter int ACC_W = 18,
  parameter int IDX_W = 5,
  parameter int SHIFT = 9,
  localparam int SYM_W = ACC_W - SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pwr_load,
  input  logic [PWR_W-1:0]        pwr_acc,
  input  logic signed [ACC_W-1:0] acc_re,
  input  logic signed [ACC_W-1:0] acc_im,
  input  logic                    chip_vld,
  input  logic [IDX_W-1:0]        chip_idx,
  input  logic                    sym_vld,
  input  logic [IDX_W-1:0]        rd_addr,
  output logic [PWR_W-1:0]        recip,
  output logic                    recip_valid,
  output logic                    recip_done,
  output logic                    div_zero,
  output logic                    est_we,
  output logic [IDX_W-1:0]        est_addr,
  output logic signed [ACC_W-1:0] est_re,
  output logic signed [ACC_W-1:0] est_im,
  output logic signed [ACC_W-1:0] rd_re,
  output logic signed [ACC_W-1:0] rd_im,
  output logic                    sym_out_vld,
  output logic signed [SYM_W-1:0] sym_re,
  output logic signed [SYM_W-1:0] sym_im
);
  logic [2*ACC_W-1:0] rd_word;

  chip_est_recip #(.PWR_W(PWR_W)) u_recip (
    .clk(clk), .rst(rst), .load(pwr_load), .pwr(pwr_acc),
    .recip(recip), .valid(recip_valid), .done(recip_done), .dz(div_zero)
  );

  chip_est_scale #(.ACC_W(ACC_W), .PWR_W(PWR_W), .IDX_W(IDX_W)) u_scale (
    .clk(clk), .rst(rst), .in_vld(chip_vld), .in_re(acc_re), .in_im(acc_im),
    .in_idx(chip_idx), .recip(recip), .recip_ok(recip_valid),
    .out_vld(est_we), .out_idx(est_addr), .out_re(est_re), .out_im(est_im)
  );

  chip_est_mem #(.DATA_W(2*ACC_W), .ADDR_W(IDX_W)) u_mem (
    .clk(clk), .we(est_we), .waddr(est_addr), .wdata({est_re, est_im}),
    .raddr(rd_addr), .rdata(rd_word)
  );

  assign rd_re = rd_word[2*ACC_W-1:ACC_W];
  assign rd_im = rd_word[ACC_W-1:0];

  chip_est_despread #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_desp (
    .clk(clk), .rst(rst), .in_vld(sym_vld),
    .in_re_hi(acc_re[ACC_W-1:SHIFT]), .in_im_hi(acc_im[ACC_W-1:SHIFT]),
    .out_vld(sym_out_vld), .out_re(sym_re), .out_im(sym_im)
  );
endmodule

// File: rtl/chip_norm_est_chk.sv
module chip_norm_est_chk #(
  parameter int PWR_W = 18,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_load,
  input logic [PWR_W-1:0] pwr_acc,
  input logic             chip_vld,
  input logic [IDX_W-1:0] chip_idx,
  input logic             sym_vld,
  input logic [PWR_W-1:0] recip,
  input logic             recip_valid,
  input logic             recip_done,
  input logic             div_zero,
  input logic             est_we,
  input logic [IDX_W-1:0] est_addr,
  input logic             sym_out_vld
);
  // R4
  zero_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_load && pwr_acc == '0) |=> (recip == '1 && recip_valid && recip_done && div_zero));
  // R4
  dz_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    div_zero |=> div_zero);
  // R3
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_load && pwr_acc != '0) |=> !recip_valid);
  // R3
  done_valid_chk: assert property (@(posedge clk) disable iff (rst)
    recip_done |-> recip_valid);
  // R6
  gated_write_chk: assert property (@(posedge clk) disable iff (rst)
    est_we |-> ($past(recip_valid, 2) && $past(chip_vld, 2)));
  // R7
  addr_track_chk: assert property (@(posedge clk) disable iff (rst)
    est_we |-> (est_addr == $past(chip_idx, 2)));
  // R8
  sym_lat_chk: assert property (@(posedge clk) disable iff (rst)
    sym_out_vld |-> $past(sym_vld));
  // R9
  recip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (recip_valid && !pwr_load) |=> ($stable(recip) && recip_valid));
endmodule

bind chip_norm_est chip_norm_est_chk #(.PWR_W(PWR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_load(pwr_load), .pwr_acc(pwr_acc),
  .chip_vld(chip_vld), .chip_idx(chip_idx), .sym_vld(sym_vld),
  .recip(recip), .recip_valid(recip_valid), .recip_done(recip_done),
  .div_zero(div_zero), .est_we(est_we), .est_addr(est_addr),
  .sym_out_vld(sym_out_vld)
);

// File: tb/chip_norm_est_bench.sv
module chip_norm_est_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst;
  logic               pwr_load;
  logic [17:0]        pwr_acc;
  logic signed [17:0] acc_re, acc_im;
  logic               chip_vld, sym_vld;
  logic [4:0]         chip_idx, rd_addr;
  logic [17:0]        recip;
  logic               recip_valid, recip_done, div_zero;
  logic               est_we;
  logic [4:0]         est_addr;
  logic signed [17:0] est_re, est_im, rd_re, rd_im;
  logic               sym_out_vld;
  logic signed [8:0]  sym_re, sym_im;

  chip_norm_est u_chip_norm_est (
    .clk(clk), .rst(rst), .pwr_load(pwr_load), .pwr_acc(pwr_acc),
    .acc_re(acc_re), .acc_im(acc_im), .chip_vld(chip_vld), .chip_idx(chip_idx),
    .sym_vld(sym_vld), .rd_addr(rd_addr), .recip(recip), .recip_valid(recip_valid),
    .recip_done(recip_done), .div_zero(div_zero), .est_we(est_we),
    .est_addr(est_addr), .est_re(est_re), .est_im(est_im), .rd_re(rd_re),
    .rd_im(rd_im), .sym_out_vld(sym_out_vld), .sym_re(sym_re), .sym_im(sym_im)
  );

  int checks = 0;
  int fails  = 0;
  longint cur_recip = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint scaled(input longint a, input longint r);
    longint p;
    logic signed [17:0] t;
    p = (a * r) >>> 17;
    t = p[17:0];
    return longint'(t);
  endfunction

  task automatic t_reset();
    chk(!recip_valid && !recip_done && !div_zero && !est_we && !sym_out_vld,
        "R1", "reset outputs", {recip_valid, recip_done, div_zero, est_we, sym_out_vld}, 0);
  endtask

  task automatic t_div(input longint p, input bit exp_dz);
    longint exp;
    exp = 131071 / p;
    @(negedge clk); pwr_load = 1'b1; pwr_acc = 18'(p);
    @(posedge clk);
    @(negedge clk); pwr_load = 1'b0;
    chk(!recip_valid, "R3", "valid low while dividing", recip_valid, 0);
    repeat (17) @(posedge clk);
    @(negedge clk);
    chk(!recip_valid, "R3", "valid low after 17 edges", recip_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(recip_valid && recip_done, "R3", "valid/done after 18 edges",
        {recip_valid, recip_done}, 3);
    chk(longint'(recip) == exp, "R2", "reciprocal value", recip, exp);
    chk(div_zero == exp_dz, "R4", "div_zero level", div_zero, exp_dz);
    cur_recip = exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(longint'(recip) == exp && !recip_done, "R9", "reciprocal held", recip, exp);
  endtask

  task automatic t_zero();
    @(negedge clk); pwr_load = 1'b1; pwr_acc = '0;
    @(posedge clk);
    @(negedge clk); pwr_load = 1'b0;
    chk(recip == 18'h3FFFF, "R4", "zero power saturates", recip, 18'h3FFFF);
    chk(recip_valid && recip_done && div_zero, "R4", "zero flags",
        {recip_valid, recip_done, div_zero}, 7);
    cur_recip = 18'h3FFFF;
  endtask

  task automatic t_chip(input int idx, input longint re, input longint im);
    longint er, ei;
    er = scaled(re, cur_recip);
    ei = scaled(im, cur_recip);
    @(negedge clk);
    chip_vld = 1'b1; chip_idx = 5'(idx); acc_re = 18'(re); acc_im = 18'(im);
    @(posedge clk);
    @(negedge clk); chip_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(est_we && est_addr == 5'(idx), "R7", "write strobe and address", est_addr, idx);
    chk(longint'(est_re) == er, "R5", "scaled real", est_re, er);
    chk(longint'(est_im) == ei, "R5", "scaled imag", est_im, ei);
  endtask

  task automatic t_read(input int idx, input longint re, input longint im, input string req);
    @(negedge clk); rd_addr = 5'(idx);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(longint'(rd_re) == re && longint'(rd_im) == im, req, "memory word",
        {rd_re, rd_im}, {18'(re), 18'(im)});
  endtask

  task automatic t_ignored();
    bit seen;
    seen = 1'b0;
    @(negedge clk); pwr_load = 1'b1; pwr_acc = 18'd5;
    @(posedge clk);
    @(negedge clk); pwr_load = 1'b0;
    chip_vld = 1'b1; chip_idx = 5'd9; acc_re = 18'sd20000; acc_im = 18'sd30000;
    @(posedge clk);
    @(negedge clk); chip_vld = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (est_we) seen = 1'b1;
    end
    chk(!seen, "R6", "no write while reciprocal invalid", seen, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_sym(input longint re, input longint im);
    longint er, ei;
    er = re >>> 9;
    ei = im >>> 9;
    @(negedge clk); sym_vld = 1'b1; acc_re = 18'(re); acc_im = 18'(im);
    @(posedge clk);
    @(negedge clk); sym_vld = 1'b0;
    chk(sym_out_vld, "R8", "despread valid", sym_out_vld, 1);
    chk(longint'(sym_re) == er && longint'(sym_im) == ei, "R8", "despread value",
        {sym_re, sym_im}, {9'(er), 9'(ei)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_load = 1'b0; pwr_acc = '0; acc_re = '0; acc_im = '0;
    chip_vld = 1'b0; sym_vld = 1'b0; chip_idx = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_div(1, 1'b0);
    t_chip(0, 5000, -7);
    t_div(3, 1'b0);
    t_div(100, 1'b0);
    t_div(131072, 1'b0);
    t_div(262143, 1'b0);
    t_zero();
    t_div(5, 1'b1);
    t_chip(3, 1000, -1000);
    t_chip(31, -131072, 131071);
    t_chip(9, -42, 77);
    t_read(3, scaled(1000, 26214), scaled(-1000, 26214), "R7");
    t_read(31, scaled(-131072, 26214), scaled(131071, 26214), "R7");
    t_ignored();
    t_read(9, scaled(-42, 26214), scaled(77, 26214), "R6");
    t_sym(1000, -1000);
    t_sym(-131072, 131071);
    t_sym(511, 512);
    repeat (2) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule